// File: doc/BRIEF.md
# Four-Phase Carrier Wipeoff Mixer

This block removes the intermediate-frequency carrier from a stream of single-bit GPS samples. It feeds the I and Q branches of a later correlator. A phase accumulator holds two integer bits and a fraction. Each time a sample arrives, the rate word is added to the accumulator. The rate is the carrier-to-sample ratio times four. Because the integer part is only two bits wide, the accumulator wraps modulo 4 on its own.

The two integer bits select one entry from a four-step sine pattern and one from a four-step cosine pattern. Each pattern entry is one bit. The sample is multiplied by both selected bits: a 1 stands for +1 and a 0 stands for −1, so the product is an XNOR. The block registers the two products together with a valid flag.

A whole-number rate, such as 1.0, visits the table entries in strict order. A fractional rate, such as 2.2764, visits them in an irregular order that follows the accumulator's fraction. When the IF is undersampled, the rate word is set from the folded carrier, which is FS − IF.

Top module: `carrier_wipeoff`

## Requirements
- R1: While reset is held, and right after it, the phase is zero and `out_vld`, `i_bit` and `q_bit` are 0.
- R2: `out_vld` is high in exactly the cycles that follow a cycle with `smp_vld` high.
- R3: The phase advances by `rate` only on a cycle with `smp_vld` high. On every other cycle it keeps its value, so a later sample sees an index that idle cycles did not disturb.
- R4: The phase is unsigned fixed point with 2 integer bits and FRAC_W fraction bits. It wraps modulo 4, and any carry out of the integer bits is dropped.
- R5: `i_bit` = XNOR(sample, S[k]), where k is the phase's integer field and S[0..3] = 1,1,0,0.
- R6: `q_bit` = XNOR(sample, C[k]), where C[0..3] = 1,0,0,1.
- R7: A sample is mixed with the index held before that sample's own increment. The first sample after reset uses index 0.
- R8: With rate 1.0, the index goes 0,1,2,3,0 in order. With a fractional rate such as 2.2764, it follows floor(n·rate) mod 4.
- R9: When no new sample arrives, `i_bit` and `q_bit` hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | A new sample is present on this cycle |
| smp_bit | input | 1 | Single-bit IF sample (1 = +1, 0 = −1) |
| rate | input | FRAC_W+2 | Phase increment per sample, 2.FRAC_W fixed point |
| i_bit | output | 1 | In-phase product |
| q_bit | output | 1 | Quadrature product |
| out_vld | output | 1 | Products are updated this cycle |

## Verification
A rate of exactly 1.0 with an unbroken sample stream shows whether the table order is right, because the index steps through each entry in turn. A rate of 2.2764 checks that the fraction is carried between samples. This rate repeats the same index with a period longer than four, so an accumulator that truncated or rounded the fraction would show up. Random rates, random samples and sparse valid strobes test wraparound near the top of the range. They also check that idle cycles neither move the phase nor change the outputs.

// File: rtl/carrier_wipeoff.sv
module carrier_wipeoff #(
  parameter int FRAC_W = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_vld,
  input  logic              smp_bit,
  input  logic [FRAC_W+1:0] rate,
  output logic              i_bit,
  output logic              q_bit,
  output logic              out_vld
);
  localparam int PH_W = FRAC_W + 2;
  localparam logic [3:0] SIN_PAT = 4'b0011;
  localparam logic [3:0] COS_PAT = 4'b1001;

  logic [PH_W-1:0] phase;
  logic [1:0]      quad;

  assign quad = phase[PH_W-1 -: 2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= '0;
      i_bit   <= 1'b0;
      q_bit   <= 1'b0;
      out_vld <= 1'b0;
    end else begin
      out_vld <= smp_vld;
      if (smp_vld) begin
        phase <= phase + rate;
        i_bit <= ~(smp_bit ^ SIN_PAT[quad]);
        q_bit <= ~(smp_bit ^ COS_PAT[quad]);
      end
    end
  end
endmodule

// File: rtl/carrier_wipeoff_chk.sv
module carrier_wipeoff_chk #(
  parameter int FRAC_W = 30
) (
  input logic              clk,
  input logic              rst_n,
  input logic              smp_vld,
  input logic              smp_bit,
  input logic [FRAC_W+1:0] rate,
  input logic [FRAC_W+1:0] phase,
  input logic              i_bit,
  input logic              q_bit,
  input logic              out_vld
);
  assert_vld_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> out_vld == $past(smp_vld));

  assert_phase_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> $stable(phase));

  assert_phase_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld |=> phase == $past(phase) + $past(rate));

  assert_iq_relation_R6: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld |=> (i_bit ^ q_bit) == $past(phase[FRAC_W]));

  assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> $stable(i_bit) && $stable(q_bit));

  assert_reset_R1: assert property (@(posedge clk)
    !rst_n |=> !out_vld && phase == '0);
endmodule

bind carrier_wipeoff carrier_wipeoff_chk #(.FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_bit(smp_bit),
  .rate(rate), .phase(phase), .i_bit(i_bit), .q_bit(q_bit), .out_vld(out_vld)
);

// File: tb/sim_carrier_wipeoff.sv
module sim_carrier_wipeoff;
  localparam int FRAC_W = 30;
  localparam int PH_W = FRAC_W + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_vld = 1'b0;
  logic smp_bit = 1'b0;
  logic [PH_W-1:0] rate = '0;
  logic i_bit, q_bit, out_vld;

  int total = 0;
  int bad = 0;

  logic [PH_W-1:0] m_phase = '0;
  logic e_i = 1'b0, e_q = 1'b0, e_v = 1'b0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  carrier_wipeoff #(.FRAC_W(FRAC_W)) u0 (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_bit(smp_bit),
    .rate(rate), .i_bit(i_bit), .q_bit(q_bit), .out_vld(out_vld)
  );

  function automatic logic sin_of(input logic [1:0] k);
    return (k == 2'd0 || k == 2'd1);
  endfunction

  function automatic logic cos_of(input logic [1:0] k);
    return (k == 2'd0 || k == 2'd3);
  endfunction

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: {vld,i,q} actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic v, input logic s);
    logic [1:0] k;
    smp_vld = v;
    smp_bit = s;
    @(negedge clk);
    e_v = v;
    if (v) begin
      k = m_phase[PH_W-1 -: 2];
      e_i = ~(s ^ sin_of(k));
      e_q = ~(s ^ cos_of(k));
      m_phase = m_phase + rate;
    end
    check(tag, {out_vld, i_bit, q_bit}, {e_v, e_i, e_q});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", {out_vld, i_bit, q_bit}, 3'b000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {out_vld, i_bit, q_bit}, 3'b000);

    // R7 and R8: rate 1.0, the index steps in order from 0
    tag = "R7_R8_rate_one";
    rate = 32'h4000_0000;
    for (int n = 0; n < 12; n++) step(1'b1, 1'b1);
    for (int n = 0; n < 8; n++) step(1'b1, 1'b0);

    // R8: fractional rate 2.2764
    tag = "R8_fractional";
    rate = PH_W'(longint'(2.2764 * 1073741824.0));
    for (int n = 0; n < 40; n++) step(1'b1, n[0] ^ n[2]);

    // R3 and R9: idle gaps keep the phase and the outputs
    tag = "R3_R9_idle";
    for (int n = 0; n < 10; n++) begin
      step(1'b0, 1'($urandom));
      step(1'b0, 1'($urandom));
      step(1'b1, 1'($urandom));
    end

    // R4: near-maximum rate forces wraparound on every sample
    tag = "R4_wrap";
    rate = 32'hFFFF_FFFF;
    for (int n = 0; n < 12; n++) step(1'b1, 1'b1);

    // R2, R5, R6: random rates, samples and strobes
    tag = "R2_R5_R6_random";
    for (int r = 0; r < 20; r++) begin
      rate = PH_W'($urandom);
      for (int n = 0; n < 100; n++) step(($urandom % 10) < 7, 1'($urandom));
    end

    // R1: reset in mid-stream clears the phase
    tag = "R1_rerun";
    rst_n = 1'b0;
    smp_vld = 1'b0;
    @(negedge clk);
    check("R1", {out_vld, i_bit, q_bit}, 3'b000);
    rst_n = 1'b1;
    m_phase = '0;
    e_i = 1'b0;
    e_q = 1'b0;
    rate = 32'h4000_0000;
    for (int n = 0; n < 4; n++) step(1'b1, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule